// File: doc/BRIEF.md
# Stereo Dry/Wet Routing Mixer

This block is the output mixing stage of one audio core. Three stereo sources come in: the summed voice output, a streamed sound-data input and an external input from another core. Each source can go to any of four destinations (dry left, dry right, wet left, wet right) through its own enable bit. The wet pair is the send to an effect processor. That processor sits outside the block, and its return comes back as a plain stereo input.

The sound-data and external sources are scaled by their own left and right volumes before routing. The effect return is scaled by a return volume and joins the dry sum only when the effect-enable attribute is set. A master volume scales the dry pair. A mute attribute forces the dry pair to zero and leaves the wet send running. All samples are signed 16-bit. A sample strobe captures one new output frame.

Configuration arrives through a write-only port:

| Address | Register |
|---|---|
| 0 | Routing register |
| 1 | Attribute register |
| 2, 3 | Sound-data volume, left / right |
| 4, 5 | External volume, left / right |
| 6, 7 | Effect-return volume, left / right |
| 8, 9 | Master volume, left / right |

All registers reset to zero.

Top module: `stereo_route_mixer`

## Requirements
- R1: The voice source is routed by routing-register bits. Bit 11 sends it to dry left, bit 10 to dry right, bit 9 to wet left and bit 8 to wet right. The voice source is not scaled.
- R2: The sound-data source is scaled by its volume (address 2 for left, 3 for right). It is then routed by bit 7 to dry left, bit 6 to dry right, bit 5 to wet left and bit 4 to wet right.
- R3: The external source is scaled by its volume (address 4 for left, 5 for right). It is then routed by bit 3 to dry left, bit 2 to dry right, bit 1 to wet left and bit 0 to wet right.
- R4: When attribute bit 7 is set, the effect return is scaled by its volume (address 6 for left, 7 for right) and added to the dry sum of the same side. When bit 7 is clear, the effect return contributes nothing.
- R5: The dry outputs equal the saturated dry sum times the master volume (address 8 for left, 9 for right). The wet outputs are not scaled by the master volume.
- R6: When attribute bit 14 is set, both dry outputs are zero. The wet outputs are unaffected.
- R7: Volumes are signed Q1.15. Each product is the full product shifted right arithmetically by 15, which rounds toward negative infinity. A product of -1 times -1 saturates to 32767.
- R8: Every sum saturates to the range -32768 to 32767 and never wraps.
- R9: The outputs load only on a clock edge where the sample strobe is high, and show the new frame one cycle later. Between strobes the outputs hold their value, including across register writes.
- R10: Reset clears all four outputs and all configuration registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write enable |
| regAddr | input | 4 | Register address |
| regWData | input | 16 | Register write data |
| sampleStb | input | 1 | Capture a new output frame |
| voiceL | input | 16 | Summed voice, left |
| voiceR | input | 16 | Summed voice, right |
| dataL | input | 16 | Sound-data input, left |
| dataR | input | 16 | Sound-data input, right |
| extL | input | 16 | External input, left |
| extR | input | 16 | External input, right |
| fxRetL | input | 16 | Effect return, left |
| fxRetR | input | 16 | Effect return, right |
| outDryL | output | 16 | Dry output, left |
| outDryR | output | 16 | Dry output, right |
| outWetL | output | 16 | Effect send, left |
| outWetR | output | 16 | Effect send, right |

## Verification
The assertions take two things for granted about the inputs:
- A register write and a strobe in the same cycle apply the old settings to that frame. The checker therefore keeps its copies of mute and routing on the same edge as the design.
- Outputs move only after a strobe, and nothing else drives them.

The stimulus keeps to this. It writes all registers in cycles where the strobe is low, then raises the strobe for exactly one cycle with the inputs already stable. It also reads every result at the falling edge after the capture.

// File: rtl/stereo_route_mixer_pkg.sv
package stereo_route_mixer_pkg;
  localparam int SAMPLE_W = 16;
  localparam int ADDR_W   = 4;
  localparam int ROUTE_W  = 12;
  localparam int ACC_W    = SAMPLE_W + 3;
  localparam int FRAC_W   = SAMPLE_W - 1;

  localparam logic [ADDR_W-1:0] A_ROUTE  = 4'd0;
  localparam logic [ADDR_W-1:0] A_ATTR   = 4'd1;
  localparam logic [ADDR_W-1:0] A_DVOL_L = 4'd2;
  localparam logic [ADDR_W-1:0] A_DVOL_R = 4'd3;
  localparam logic [ADDR_W-1:0] A_EVOL_L = 4'd4;
  localparam logic [ADDR_W-1:0] A_EVOL_R = 4'd5;
  localparam logic [ADDR_W-1:0] A_FVOL_L = 4'd6;
  localparam logic [ADDR_W-1:0] A_FVOL_R = 4'd7;
  localparam logic [ADDR_W-1:0] A_MVOL_L = 4'd8;
  localparam logic [ADDR_W-1:0] A_MVOL_R = 4'd9;

  localparam int ATTR_FX_BIT   = 7;
  localparam int ATTR_MUTE_BIT = 14;

  typedef logic signed [SAMPLE_W-1:0] sample_t;

  // control to datapath: capture strobe plus decoded settings; index 0 = left, 1 = right
  typedef struct packed {
    logic                        capture;
    logic [ROUTE_W-1:0]          route;
    logic                        fxEn;
    logic                        mute;
    logic [1:0][SAMPLE_W-1:0]    dataVol;
    logic [1:0][SAMPLE_W-1:0]    extVol;
    logic [1:0][SAMPLE_W-1:0]    fxVol;
    logic [1:0][SAMPLE_W-1:0]    masterVol;
  } mix_ctl_t;

  function automatic sample_t satAcc(input logic signed [ACC_W-1:0] x);
    localparam logic signed [ACC_W-1:0] HI = ACC_W'(2**(SAMPLE_W-1) - 1);
    localparam logic signed [ACC_W-1:0] LO = -ACC_W'(2**(SAMPLE_W-1));
    if (x > HI)      return sample_t'(HI);
    else if (x < LO) return sample_t'(LO);
    else             return sample_t'(x);
  endfunction

  // Q1.15 multiply, floor rounding, saturating
  function automatic sample_t qMul(input sample_t a, input sample_t b);
    logic signed [2*SAMPLE_W-1:0] prod;
    logic signed [2*SAMPLE_W-1:0] shifted;
    prod    = a * b;
    shifted = prod >>> FRAC_W;
    return satAcc(ACC_W'(shifted));
  endfunction
endpackage

// File: rtl/stereo_route_mixer_ctrl.sv
module stereo_route_mixer_ctrl
  import stereo_route_mixer_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [SAMPLE_W-1:0] regWData,
  input  logic                sampleStb,
  output mix_ctl_t            ctl
);
  logic [ROUTE_W-1:0]       routeReg;
  logic [SAMPLE_W-1:0]      attrReg;
  logic [1:0][SAMPLE_W-1:0] dVol, eVol, fVol, mVol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      routeReg <= '0;
      attrReg  <= '0;
      dVol     <= '0;
      eVol     <= '0;
      fVol     <= '0;
      mVol     <= '0;
    end else if (regWe) begin
      case (regAddr)
        A_ROUTE:  routeReg <= regWData[ROUTE_W-1:0];
        A_ATTR:   attrReg  <= regWData;
        A_DVOL_L: dVol[0]  <= regWData;
        A_DVOL_R: dVol[1]  <= regWData;
        A_EVOL_L: eVol[0]  <= regWData;
        A_EVOL_R: eVol[1]  <= regWData;
        A_FVOL_L: fVol[0]  <= regWData;
        A_FVOL_R: fVol[1]  <= regWData;
        A_MVOL_L: mVol[0]  <= regWData;
        A_MVOL_R: mVol[1]  <= regWData;
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl.capture   = sampleStb;
    ctl.route     = routeReg;
    ctl.fxEn      = attrReg[ATTR_FX_BIT];
    ctl.mute      = attrReg[ATTR_MUTE_BIT];
    ctl.dataVol   = dVol;
    ctl.extVol    = eVol;
    ctl.fxVol     = fVol;
    ctl.masterVol = mVol;
  end
endmodule

// File: rtl/stereo_route_mixer_dp.sv
module stereo_route_mixer_dp
  import stereo_route_mixer_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  mix_ctl_t                 ctl,
  input  logic [1:0][SAMPLE_W-1:0] voiceIn,
  input  logic [1:0][SAMPLE_W-1:0] dataIn,
  input  logic [1:0][SAMPLE_W-1:0] extIn,
  input  logic [1:0][SAMPLE_W-1:0] fxIn,
  output logic [1:0][SAMPLE_W-1:0] dryOut,
  output logic [1:0][SAMPLE_W-1:0] wetOut
);
  for (genvar s = 0; s < 2; s++) begin : g_side
    // routing bit positions: left side uses the higher bit of each pair
    localparam int V_DRY = 11 - s;
    localparam int V_WET = 9 - s;
    localparam int D_DRY = 7 - s;
    localparam int D_WET = 5 - s;
    localparam int E_DRY = 3 - s;
    localparam int E_WET = 1 - s;

    sample_t dataScaled, extScaled, fxScaled, drySat, dryNext, wetNext;
    logic signed [ACC_W-1:0] drySum, wetSum;

    always_comb begin
      dataScaled = qMul(sample_t'(dataIn[s]), sample_t'(ctl.dataVol[s]));
      extScaled  = qMul(sample_t'(extIn[s]),  sample_t'(ctl.extVol[s]));
      fxScaled   = ctl.fxEn ? qMul(sample_t'(fxIn[s]), sample_t'(ctl.fxVol[s])) : '0;
      drySum = ACC_W'(fxScaled);
      wetSum = '0;
      if (ctl.route[V_DRY]) drySum = drySum + ACC_W'(sample_t'(voiceIn[s]));
      if (ctl.route[D_DRY]) drySum = drySum + ACC_W'(dataScaled);
      if (ctl.route[E_DRY]) drySum = drySum + ACC_W'(extScaled);
      if (ctl.route[V_WET]) wetSum = wetSum + ACC_W'(sample_t'(voiceIn[s]));
      if (ctl.route[D_WET]) wetSum = wetSum + ACC_W'(dataScaled);
      if (ctl.route[E_WET]) wetSum = wetSum + ACC_W'(extScaled);
      drySat  = satAcc(drySum);
      dryNext = ctl.mute ? '0 : qMul(drySat, sample_t'(ctl.masterVol[s]));
      wetNext = satAcc(wetSum);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dryOut[s] <= '0;
        wetOut[s] <= '0;
      end else if (ctl.capture) begin
        dryOut[s] <= dryNext;
        wetOut[s] <= wetNext;
      end
    end
  end
endmodule

// File: rtl/stereo_route_mixer.sv
module stereo_route_mixer
  import stereo_route_mixer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        regWe,
  input  logic [3:0]  regAddr,
  input  logic [15:0] regWData,
  input  logic        sampleStb,
  input  logic [15:0] voiceL,
  input  logic [15:0] voiceR,
  input  logic [15:0] dataL,
  input  logic [15:0] dataR,
  input  logic [15:0] extL,
  input  logic [15:0] extR,
  input  logic [15:0] fxRetL,
  input  logic [15:0] fxRetR,
  output logic [15:0] outDryL,
  output logic [15:0] outDryR,
  output logic [15:0] outWetL,
  output logic [15:0] outWetR
);
  mix_ctl_t ctl;
  logic [1:0][SAMPLE_W-1:0] dryOut, wetOut;

  stereo_route_mixer_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr),
    .regWData(regWData), .sampleStb(sampleStb), .ctl(ctl)
  );

  stereo_route_mixer_dp dp_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .voiceIn({voiceR, voiceL}), .dataIn({dataR, dataL}),
    .extIn({extR, extL}), .fxIn({fxRetR, fxRetL}),
    .dryOut(dryOut), .wetOut(wetOut)
  );

  assign outDryL = dryOut[0];
  assign outDryR = dryOut[1];
  assign outWetL = wetOut[0];
  assign outWetR = wetOut[1];
endmodule

// File: rtl/stereo_route_mixer_chk.sv
module stereo_route_mixer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        regWe,
  input logic [3:0]  regAddr,
  input logic [15:0] regWData,
  input logic        sampleStb,
  input logic [15:0] outDryL,
  input logic [15:0] outDryR,
  input logic [15:0] outWetL,
  input logic [15:0] outWetR
);
  logic        muteCopy;
  logic [11:0] routeCopy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      muteCopy  <= 1'b0;
      routeCopy <= '0;
    end else if (regWe) begin
      if (regAddr == 4'd1) muteCopy  <= regWData[14];
      if (regAddr == 4'd0) routeCopy <= regWData[11:0];
    end
  end

  // R10: outputs are zero when reset is released
  a_r10_reset_zero: assert property (@(posedge clk)
    $rose(rst_n) |-> (outDryL == 16'd0 && outDryR == 16'd0 && outWetL == 16'd0 && outWetR == 16'd0));

  // R9: no strobe, no change
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleStb |=> ($stable(outDryL) && $stable(outDryR) && $stable(outWetL) && $stable(outWetR)));

  // R6: muted frame has silent dry pair
  a_r6_mute_dry: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleStb && muteCopy) |=> (outDryL == 16'd0 && outDryR == 16'd0));

  // R1: no wet route bits means a silent send
  a_r1_no_wet_route: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleStb && routeCopy[9:8] == 2'b00 && routeCopy[5:4] == 2'b00 && routeCopy[1:0] == 2'b00)
      |=> (outWetL == 16'd0 && outWetR == 16'd0));
endmodule

bind stereo_route_mixer stereo_route_mixer_chk chk_i (.*);

// File: tb/stereo_route_mixer_tb.sv
module stereo_route_mixer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWData = '0;
  logic        sampleStb = 1'b0;
  logic [15:0] voiceL = '0, voiceR = '0, dataL = '0, dataR = '0;
  logic [15:0] extL = '0, extR = '0, fxRetL = '0, fxRetR = '0;
  logic [15:0] outDryL, outDryR, outWetL, outWetR;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  stereo_route_mixer dut_i (.*);

  typedef struct packed {
    logic [15:0] route, attr, vol, mvol;
    logic [15:0] vL, vR, dL, dR, eL, eR, fL, fR;
    logic [15:0] xDL, xDR, xWL, xWR;
  } vec_t;

  // route, attr, vol, master, voice L/R, data L/R, ext L/R, fx L/R, expected dryL dryR wetL wetR
  localparam vec_t VECS [12] = '{
    '{16'h0C00, 16'h0000, 16'h4000, 16'h4000, 16'd1000, -16'sd1000, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd500, -16'sd500, 16'd0, 16'd0},
    '{16'h0300, 16'h0000, 16'h4000, 16'h4000, 16'd1000, -16'sd2000, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd1000, -16'sd2000},
    '{16'h0900, 16'h0000, 16'h4000, 16'h4000, 16'd400, 16'd600, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd200, 16'd0, 16'd0, 16'd600},
    '{16'h00F0, 16'h0000, 16'h4000, 16'h4000, 16'd0, 16'd0, 16'd1000, -16'sd1000, 16'd0, 16'd0, 16'd0, 16'd0, 16'd250, -16'sd250, 16'd500, -16'sd500},
    '{16'h000F, 16'h0000, 16'h4000, 16'h4000, 16'd0, 16'd0, 16'd0, 16'd0, 16'd3000, -16'sd3, 16'd0, 16'd0, 16'd750, -16'sd1, 16'd1500, -16'sd2},
    '{16'h0C00, 16'h0080, 16'h4000, 16'h4000, 16'd1000, 16'd1000, 16'd0, 16'd0, 16'd0, 16'd0, 16'd2000, -16'sd4000, 16'd1000, -16'sd500, 16'd0, 16'd0},
    '{16'h0C00, 16'h0000, 16'h4000, 16'h4000, 16'd1000, 16'd1000, 16'd0, 16'd0, 16'd0, 16'd0, 16'd2000, -16'sd4000, 16'd500, 16'd500, 16'd0, 16'd0},
    '{16'h0FFF, 16'h4080, 16'h4000, 16'h4000, 16'd100, 16'd100, 16'd200, 16'd200, 16'd400, 16'd400, 16'd0, 16'd0, 16'd0, 16'd0, 16'd400, 16'd400},
    '{16'h0330, 16'h0000, 16'h7FFF, 16'h4000, 16'd30000, -16'sd30000, 16'd30000, -16'sd30000, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'h7FFF, 16'h8000},
    '{16'h0CC0, 16'h0000, 16'h7FFF, 16'h7FFF, 16'd30000, -16'sd30000, 16'd30000, -16'sd30000, 16'd0, 16'd0, 16'd0, 16'd0, 16'd32766, -16'sd32767, 16'd0, 16'd0},
    '{16'h000C, 16'h0000, 16'h8000, 16'h7FFF, 16'd0, 16'd0, 16'd0, 16'd0, 16'h8000, 16'h8000, 16'd0, 16'd0, 16'd32766, 16'd32766, 16'd0, 16'd0},
    '{16'h0FFF, 16'h0080, 16'h4000, 16'h4000, 16'd100, -16'sd100, 16'd40, -16'sd40, 16'd20, -16'sd20, 16'd10, -16'sd10, 16'd67, -16'sd68, 16'd130, -16'sd130}
  };

  // requirement tags per vector, for messages
  localparam string TAGS [12] = '{"R1", "R1 R5", "R1", "R2", "R3 R7", "R4", "R4",
                                  "R6", "R8", "R8 R5", "R7", "R1 R2 R3 R4"};

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what,
               $signed(act), $signed(exp));
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWData = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk);
    sampleStb = 1'b1;
    @(negedge clk);
    sampleStb = 1'b0;
  endtask

  task automatic checkOuts(input string tag, input logic [15:0] a, input logic [15:0] b,
                           input logic [15:0] c, input logic [15:0] d);
    check(tag, "dryL", outDryL, a);
    check(tag, "dryR", outDryR, b);
    check(tag, "wetL", outWetL, c);
    check(tag, "wetR", outWetR, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    checkOuts("R10", 16'd0, 16'd0, 16'd0, 16'd0);

    for (int i = 0; i < 12; i++) begin
      wr(4'd0, VECS[i].route);
      wr(4'd1, VECS[i].attr);
      for (int a = 2; a < 8; a++) wr(4'(a), VECS[i].vol);
      wr(4'd8, VECS[i].mvol);
      wr(4'd9, VECS[i].mvol);
      voiceL = VECS[i].vL; voiceR = VECS[i].vR;
      dataL  = VECS[i].dL; dataR  = VECS[i].dR;
      extL   = VECS[i].eL; extR   = VECS[i].eR;
      fxRetL = VECS[i].fL; fxRetR = VECS[i].fR;
      strobe();
      checkOuts(TAGS[i], VECS[i].xDL, VECS[i].xDR, VECS[i].xWL, VECS[i].xWR);
    end

    // R9: new inputs and register writes without a strobe leave outputs held
    voiceL = 16'd2000; voiceR = 16'd2000;
    dataL = '0; dataR = '0; extL = '0; extR = '0; fxRetL = '0; fxRetR = '0;
    wr(4'd1, 16'h0000);
    wr(4'd0, 16'h0C00);
    repeat (3) @(negedge clk);
    checkOuts("R9", 16'd67, -16'sd68, 16'd130, -16'sd130);

    // R9: one strobe cycle, result visible right after that edge
    strobe();
    checkOuts("R9", 16'd1000, 16'd1000, 16'd0, 16'd0);

    // R10: mid-run reset clears outputs and registers
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    checkOuts("R10", 16'd0, 16'd0, 16'd0, 16'd0);
    strobe();
    checkOuts("R10", 16'd0, 16'd0, 16'd0, 16'd0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule